// File: doc/BRIEF.md
# Parameterised Bidirectional Shift Unit

This block is a purely combinational shifter for datapaths whose operand, shift-amount and result widths are chosen independently. A 3-bit operation code picks the kind of shift. Four codes follow the familiar HDL shift operators. Two more codes shift in a direction set by the sign of the amount. One of those two leaves vacated bit positions undefined, in the way an indexed part-select reading past the end of a vector does.

The operand is first widened to a working width. That width is the larger of the operand width and the result width. Widening uses sign extension when the operand is declared signed and zero extension otherwise. The shift runs at the working width, and the low result-width bits are then taken as the output. A shift distance that reaches or exceeds the working width leaves only fill bits.

The unit sits between operand-select logic and a result bus, with no clock and no state. Its parameters are `A_W`, `B_W`, `Y_W`, `A_SGN` and `B_SGN`.

Top module: `shift_unit`

## Requirements
- R1: With op code 0 (logical left), Y is the working-width operand shifted toward the MSB by B, with zeros entering at the LSB end.
- R2: Op code 2 (arithmetic left) gives a result identical to op code 0 for every operand and amount.
- R3: With op code 1 (logical right), the working-width operand moves toward the LSB by B, with zeros entering at the MSB end.
- R4: With op code 3 (arithmetic right), vacated high bits are filled with the operand's MSB when A_SGN is nonzero and with zeros when A_SGN is zero.
- R5: The operand is sign-extended (A_SGN nonzero) or zero-extended (A_SGN zero) to the working width max(A_W, Y_W), and the result is the low Y_W bits of the shifted value.
- R6: Op codes 0 to 3 read B as an unsigned number whatever B_SGN is; an amount with its top bit set shifts by its large unsigned value.
- R7: With op code 4 (bidirectional), a non-negative amount, or any amount when B_SGN is zero, shifts right logically. A negative signed amount shifts left logically by its magnitude.
- R8: Op code 5 moves bits exactly as op code 4 does, but every vacated position is x instead of 0.
- R9: A distance at or beyond the working width yields only fill bits: zeros for the logical modes, copies of the fill bit of R4 for arithmetic right, and x for op code 5.
- R10: Op codes 6 and 7 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | A_W | Operand to be shifted |
| b | input | B_W | Shift amount, signed for op code 4 and 5 when B_SGN is nonzero |
| op | input | 3 | Operation code (0 lsl, 1 lsr, 2 asl, 3 asr, 4 bidir, 5 bidir with x fill) |
| y | output | Y_W | Shifted, width-fitted result |

## Verification
The bench builds two copies of the unit. The first has a signed 8-bit operand, a signed 5-bit amount and a 12-bit result. Its operand is sign-extended on the way in, a negative amount turns the bidirectional modes leftward, and amounts above 11 reach saturation in both directions. The second has an unsigned 12-bit operand, an unsigned 5-bit amount and a 6-bit result. This exposes truncation of the upper shifted bits, zero fill on arithmetic right, and a bidirectional mode that can only go right. For the x-fill mode, only the positions expected to hold real data are compared.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [2:0] {
        OP_LSL  = 3'd0,
        OP_LSR  = 3'd1,
        OP_ASL  = 3'd2,
        OP_ASR  = 3'd3,
        OP_BID  = 3'd4,
        OP_BIDX = 3'd5
    } sh_op_e;

    // Control word produced by the amount decoder for the shift core.
    typedef struct packed {
        logic to_left;   // direction toward MSB
        logic sat;       // distance covers the whole working width
        logic fill_x;    // vacated bits become undefined
        logic fill_sgn;  // vacated bits take the operand sign
        logic kill;      // unused op code: force zero
    } sh_ctl_t;

    function automatic int max_of(input int x, input int z);
        return (x > z) ? x : z;
    endfunction

    // Number of bits needed to index a distance in [0, n-1]; at least 1.
    function automatic int idx_bits(input int n);
        int r;
        r = 1;
        while ((1 << r) < n) r++;
        return r;
    endfunction

endpackage

// File: rtl/shu_extend.sv
module shu_extend #(
    parameter int A_W   = 8,
    parameter int W     = 12,
    parameter bit A_SGN = 1'b1
) (
    input  logic [A_W-1:0] a,
    output logic [W-1:0]   aw,
    output logic           sgn
);
    localparam int PAD = W - A_W;

    assign sgn = A_SGN ? a[A_W-1] : 1'b0;

    generate
        if (PAD > 0) begin : g_pad
            assign aw = {{PAD{sgn}}, a};
        end else begin : g_same
            assign aw = a;
        end
    endgenerate
endmodule

// File: rtl/shu_decode.sv
module shu_decode
    import shift_pkg::*;
#(
    parameter int B_W   = 5,
    parameter bit B_SGN = 1'b1,
    parameter int W     = 12,
    parameter int MAG_W = B_W + 1
) (
    input  logic [2:0]       op,
    input  logic [B_W-1:0]   b,
    output sh_ctl_t          ctl,
    output logic [MAG_W-1:0] mag
);
    logic             bidir;
    logic             neg;
    logic [MAG_W-1:0] b_zx;
    logic [MAG_W-1:0] b_sx;

    assign bidir = (op == OP_BID) || (op == OP_BIDX);
    assign neg   = B_SGN && b[B_W-1];
    assign b_zx  = {1'b0, b};
    assign b_sx  = {b[B_W-1], b};

    always_comb begin
        mag          = b_zx;
        ctl.to_left  = 1'b0;
        ctl.fill_x   = 1'b0;
        ctl.fill_sgn = 1'b0;
        ctl.kill     = 1'b0;
        unique case (op)
            OP_LSL, OP_ASL: ctl.to_left = 1'b1;
            OP_LSR:         ctl.to_left = 1'b0;
            OP_ASR:         ctl.fill_sgn = 1'b1;
            OP_BID, OP_BIDX: begin
                ctl.fill_x = (op == OP_BIDX);
                if (bidir && neg) begin
                    ctl.to_left = 1'b1;
                    mag         = MAG_W'(0) - b_sx;
                end
            end
            default:        ctl.kill = 1'b1;
        endcase
        ctl.sat = (int'(mag) >= W);
    end
endmodule

// File: rtl/shu_barrel.sv
module shu_barrel
    import shift_pkg::*;
#(
    parameter int W     = 12,
    parameter int MAG_W = 6
) (
    input  logic [W-1:0]     aw,
    input  logic             sgn,
    input  sh_ctl_t          ctl,
    input  logic [MAG_W-1:0] mag,
    output logic [W-1:0]     res
);
    localparam int STG = idx_bits(W);
    localparam int USE = (STG < MAG_W) ? STG : MAG_W;

    logic           fill;
    logic [W-1:0]   stage [USE+1];

    always_comb begin
        if (ctl.fill_x)        fill = 1'bx;
        else if (ctl.fill_sgn) fill = sgn;
        else                   fill = 1'b0;
    end

    assign stage[0] = aw;

    generate
        for (genvar k = 0; k < USE; k++) begin : g_stage
            localparam int D = 1 << k;
            always_comb begin
                for (int i = 0; i < W; i++) begin
                    if (!mag[k]) begin
                        stage[k+1][i] = stage[k][i];
                    end else if (ctl.to_left) begin
                        stage[k+1][i] = (i >= D) ? stage[k][i-D] : fill;
                    end else begin
                        stage[k+1][i] = (i + D < W) ? stage[k][i+D] : fill;
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        if (ctl.sat) res = {W{fill}};
        else         res = stage[USE];
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int A_W   = 8,
    parameter int B_W   = 5,
    parameter int Y_W   = 12,
    parameter bit A_SGN = 1'b1,
    parameter bit B_SGN = 1'b1
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    input  logic [2:0]     op,
    output logic [Y_W-1:0] y
);
    localparam int W     = max_of(A_W, Y_W);
    localparam int MAG_W = B_W + 1;

    logic [W-1:0]     aw;
    logic             sgn;
    sh_ctl_t          ctl;
    logic [MAG_W-1:0] mag;
    logic [W-1:0]     res;

    shu_extend #(.A_W(A_W), .W(W), .A_SGN(A_SGN)) u_ext (
        .a(a), .aw(aw), .sgn(sgn)
    );

    shu_decode #(.B_W(B_W), .B_SGN(B_SGN), .W(W), .MAG_W(MAG_W)) u_dec (
        .op(op), .b(b), .ctl(ctl), .mag(mag)
    );

    shu_barrel #(.W(W), .MAG_W(MAG_W)) u_bar (
        .aw(aw), .sgn(sgn), .ctl(ctl), .mag(mag), .res(res)
    );

    assign y = ctl.kill ? '0 : res[Y_W-1:0];
endmodule

// File: rtl/shu_checker.sv
module shu_checker #(
    parameter int A_W   = 8,
    parameter int B_W   = 5,
    parameter int Y_W   = 12,
    parameter bit A_SGN = 1'b1,
    parameter bit B_SGN = 1'b1
) (
    input logic [A_W-1:0] a,
    input logic [B_W-1:0] b,
    input logic [2:0]     op,
    input logic [Y_W-1:0] y
);
    localparam int W = (A_W > Y_W) ? A_W : Y_W;

    logic [Y_W-1:0] fit_a;
    logic           top;

    always_comb begin
        top = A_SGN ? a[A_W-1] : 1'b0;
        for (int i = 0; i < Y_W; i++) fit_a[i] = (i < A_W) ? a[i] : top;
    end

    always_comb begin
        // R5: zero distance returns the fitted operand
        if (op <= 3'd4 && b == '0)
            p_zero_amount_r5: assert (y == fit_a);
        // R1: left shifts leave zeros below the distance
        if (op == 3'd0 || op == 3'd2)
            for (int i = 0; i < Y_W; i++)
                if (i < int'(b))
                    p_left_low_zero_r1: assert (y[i] == 1'b0);
        // R9: logical right saturates to zero
        if (op == 3'd1 && int'(b) >= W)
            p_lsr_sat_r9: assert (y == '0);
        // R4: arithmetic right saturates to the fill bit
        if (op == 3'd3 && int'(b) >= W)
            p_asr_sat_r4: assert (y == {Y_W{top}});
        // R10: unused codes give zero
        if (op >= 3'd6)
            p_badop_zero_r10: assert (y == '0);
    end
endmodule

bind shift_unit shu_checker #(
    .A_W(A_W), .B_W(B_W), .Y_W(Y_W), .A_SGN(A_SGN), .B_SGN(B_SGN)
) u_chk (.a(a), .b(b), .op(op), .y(y));

// File: tb/test_shift_unit.sv
module test_shift_unit;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Copy 1: signed 8-bit operand, signed 5-bit amount, 12-bit result
    logic [7:0]  a1;
    logic [4:0]  b1;
    logic [2:0]  op1;
    logic [11:0] y1;
    // Copy 2: unsigned 12-bit operand, unsigned 5-bit amount, 6-bit result
    logic [11:0] a2;
    logic [4:0]  b2;
    logic [2:0]  op2;
    logic [5:0]  y2;

    shift_unit #(.A_W(8), .B_W(5), .Y_W(12), .A_SGN(1'b1), .B_SGN(1'b1)) i_shift_unit (
        .a(a1), .b(b1), .op(op1), .y(y1)
    );
    shift_unit #(.A_W(12), .B_W(5), .Y_W(6), .A_SGN(1'b0), .B_SGN(1'b0)) i_shift_unit_u (
        .a(a2), .b(b2), .op(op2), .y(y2)
    );

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R3";
            3'd2: return "R2";
            3'd3: return "R4";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R10";
        endcase
    endfunction

    // Reference for copy 1 (working width 12)
    function automatic logic [11:0] ref1(input logic [7:0] a, input logic [4:0] b,
                                         input logic [2:0] o, output logic [11:0] known);
        logic [11:0] aw;
        logic [11:0] r;
        int bi;
        aw = {{4{a[7]}}, a};
        bi = int'($signed(b));
        known = '1;
        case (o)
            3'd0:    r = aw << b;
            3'd2:    r = aw <<< b;
            3'd1:    r = aw >> b;
            3'd3:    r = $unsigned($signed(aw) >>> b);
            3'd4:    r = (bi < 0) ? (aw << (-bi)) : (aw >> bi);
            3'd5: begin
                for (int i = 0; i < 12; i++) begin
                    int s;
                    s = i + bi;
                    if (s >= 0 && s < 12) r[i] = aw[s];
                    else begin r[i] = 1'bx; known[i] = 1'b0; end
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    // Reference for copy 2 (working width 12, result 6, unsigned)
    function automatic logic [5:0] ref2(input logic [11:0] a, input logic [4:0] b,
                                        input logic [2:0] o, output logic [5:0] known);
        logic [11:0] r;
        logic [11:0] kw;
        kw = '1;
        case (o)
            3'd0, 3'd2: r = a << b;
            3'd1, 3'd3, 3'd4: r = a >> b;
            3'd5: begin
                for (int i = 0; i < 12; i++) begin
                    if (i + int'(b) < 12) r[i] = a[i + int'(b)];
                    else begin r[i] = 1'bx; kw[i] = 1'b0; end
                end
            end
            default: r = '0;
        endcase
        known = kw[5:0];
        return r[5:0];
    endfunction

    task automatic check1(input string tag);
        logic [11:0] k;
        logic [11:0] e;
        e = ref1(a1, b1, op1, k);
        checks++;
        if (((y1 ^ e) & k) != '0) begin
            errors++;
            $display("FAIL %s copy1 a=%h b=%h op=%0d y=%h expected=%h mask=%h",
                     tag, a1, b1, op1, y1, e, k);
        end
    endtask

    task automatic check2(input string tag);
        logic [5:0] k;
        logic [5:0] e;
        e = ref2(a2, b2, op2, k);
        checks++;
        if (((y2 ^ e) & k) != '0) begin
            errors++;
            $display("FAIL %s copy2 a=%h b=%h op=%0d y=%h expected=%h mask=%h",
                     tag, a2, b2, op2, y2, e, k);
        end
    endtask

    task automatic drive(input logic [7:0] xa1, input logic [4:0] xb1, input logic [2:0] xo1,
                         input logic [11:0] xa2, input logic [4:0] xb2, input logic [2:0] xo2);
        @(posedge clk);
        #2;
        a1 = xa1; b1 = xb1; op1 = xo1;
        a2 = xa2; b2 = xb2; op2 = xo2;
        @(negedge clk);
    endtask

    initial begin
        logic [11:0] y_lsl;
        a1 = '0; b1 = '0; op1 = '0; a2 = '0; b2 = '0; op2 = '0;
        repeat (2) @(posedge clk);

        // R5: sign extension of a negative operand with zero distance
        drive(8'h9C, 5'd0, 3'd0, 12'hA5C, 5'd0, 3'd1);
        check1("R5"); check2("R5");
        // R1 / R3 basic distances
        drive(8'h81, 5'd3, 3'd0, 12'hF0F, 5'd4, 3'd1);
        check1("R1"); check2("R3");
        // R2: left logical then left arithmetic on same data must match
        drive(8'hC3, 5'd5, 3'd0, 12'h123, 5'd2, 3'd0);
        y_lsl = y1;
        check1("R1");
        drive(8'hC3, 5'd5, 3'd2, 12'h123, 5'd2, 3'd2);
        check1("R2"); check2("R2");
        checks++;
        if (y1 != y_lsl) begin
            errors++;
            $display("FAIL R2 lsl/asl mismatch y=%h expected=%h", y1, y_lsl);
        end
        // R4: signed fill vs unsigned zero fill
        drive(8'h90, 5'd9, 3'd3, 12'hF00, 5'd3, 3'd3);
        check1("R4"); check2("R4");
        // R6: top-bit-set amount in a fixed-direction mode is a large unsigned distance
        drive(8'h7F, 5'b11111, 3'd0, 12'hFFF, 5'd17, 3'd1);
        check1("R6"); check2("R6");
        drive(8'h01, 5'b10001, 3'd1, 12'h001, 5'd0, 3'd0);
        check1("R6");
        // R7: negative amount goes left, positive goes right
        drive(8'h35, 5'b11110, 3'd4, 12'hABC, 5'd4, 3'd4);
        check1("R7"); check2("R7");
        drive(8'hB5, 5'd2, 3'd4, 12'hABC, 5'd0, 3'd4);
        check1("R7");
        // R8: undefined fill, both directions
        drive(8'h6D, 5'b11101, 3'd5, 12'h5A5, 5'd3, 3'd5);
        check1("R8"); check2("R8");
        drive(8'h6D, 5'd4, 3'd5, 12'h5A5, 5'd9, 3'd5);
        check1("R8"); check2("R8");
        // R9: saturation in each mode
        drive(8'h80, 5'd15, 3'd3, 12'hFFF, 5'd12, 3'd1);
        check1("R9"); check2("R9");
        drive(8'hFF, 5'd12, 3'd1, 12'hFFF, 5'd31, 3'd0);
        check1("R9"); check2("R9");
        drive(8'h55, 5'b10000, 3'd4, 12'h800, 5'd20, 3'd3);
        check1("R9"); check2("R9");
        // R10: unused codes
        drive(8'hFF, 5'd1, 3'd6, 12'hFFF, 5'd1, 3'd7);
        check1("R10"); check2("R10");

        // Random sweep, compared every cycle
        for (int n = 0; n < 1500; n++) begin
            logic [2:0] o1;
            logic [2:0] o2;
            o1 = 3'($urandom_range(0, 7));
            o2 = 3'($urandom_range(0, 7));
            drive(8'($urandom), 5'($urandom), o1, 12'($urandom), 5'($urandom), o2);
            check1(tag_of(o1));
            check2(tag_of(o2));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule